// File: doc/BRIEF.md
# Four-Frame Ring Sample Buffer with Alternating Memory Access

This block captures packed ADC sample words into a single-port memory that is split into four frames and used as a ring. The write side is driven by a free-running frame-synch pulse: each pulse closes the frame being filled and moves the write pointer to the next frame, wrapping from the last frame back to the first. Each word holds two 16-bit samples, so a group of 64 channels at 2 MHz gives a 64 MHz word stream. The memory runs at twice that rate. Its cycles alternate strictly between a write slot and a read slot, so capture never waits for readout.

Every closed frame is read back in the order it was written. Each word is tagged with its frame number and with first and last markers. A trigger seen while a frame is filling marks that frame for the priority path; its words come out on `pri_valid_o`. Unmarked frames come out on `cont_valid_o`. If the writer has to re-enter a frame that is still waiting for readout, or is still being read, the block reports an overflow, drops that frame's readout and keeps writing.

A run/init input holds the block idle with its pointers at frame 0. Capture begins at the first frame-synch pulse after init is released. Frame length is set by the spacing of the synch pulses, up to the `WORDS_PER_FRAME` capacity.

Top module: `sbuf_frame_ring`

## Requirements
- R1: While `init_i` is 1, no word is stored, `wr_frame_o` is 0, `running_o` is 0, `frame_ready_o` is 0 and no readout strobe fires. After `init_i` returns to 0, capture starts at the next `frame_sync_i` pulse, into frame 0.
- R2: A word on `word_i` is stored only in a cycle where `word_slot_o` is 1. `word_slot_o` is 1 in every other cycle. Readout strobes (`pri_valid_o` or `cont_valid_o`) never fire in two consecutive cycles.
- R3: Each `frame_sync_i` pulse while running closes the current frame and advances `wr_frame_o` by one in the ring 0,1,2,3,0.
- R4: Each closed frame holding at least one word is read out once, after any older pending frames. Its words come out in write order with `rd_frame_o` equal to the frame number. `rd_first_o` is 1 on its first word and `rd_last_o` is 1 on its last word.
- R5: A frame in which `trigger_i` was 1 in any cycle, including the synch cycle that opened it, is read out on `pri_valid_o`. Any other frame is read out on `cont_valid_o`. The two strobes are never 1 together.
- R6: Words beyond `WORDS_PER_FRAME` within one frame are dropped. Such a frame reads out exactly `WORDS_PER_FRAME` words.
- R7: If a synch pulse moves the writer into a frame still pending readout, `ovf_o` pulses for one cycle with `ovf_frame_o` set to that frame. The rest of that frame's readout is dropped, with no last marker. Writing continues, and later frames read out normally.
- R8: A word presented in the same cycle as a synch pulse becomes word 0 of the newly opened frame.
- R9: Raising `init_i` during a run discards the open frame and every pending frame. None of their words reach the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, twice the word rate |
| rst_n | input | 1 | Synchronous active-low reset |
| init_i | input | 1 | 1 = init (idle, pointers at frame 0), 0 = run |
| frame_sync_i | input | 1 | Frame boundary pulse from the free-running sampler |
| trigger_i | input | 1 | Marks the frame being filled for the priority path |
| word_valid_i | input | 1 | A packed sample word is present |
| word_i | input | 32 | Two 16-bit samples |
| word_slot_o | output | 1 | 1 when the current cycle is a write slot |
| pri_valid_o | output | 1 | Readout word of a triggered frame |
| cont_valid_o | output | 1 | Readout word of an untriggered frame |
| rd_data_o | output | 32 | Readout word |
| rd_frame_o | output | 2 | Frame number of the readout word |
| rd_first_o | output | 1 | First word of the frame |
| rd_last_o | output | 1 | Last word of the frame |
| wr_frame_o | output | 2 | Frame currently being written |
| running_o | output | 1 | Capture active |
| frame_ready_o | output | 4 | Frames closed and waiting for readout |
| ovf_o | output | 1 | One-cycle overflow pulse |
| ovf_frame_o | output | 2 | Frame whose readout was dropped |

## Verification
Two things can land in the same clock edge: a synch pulse that re-enters a frame, and the reader's ongoing readout of that same frame. The test fills frame 0 to capacity and lets its readout begin. It then fires three synch pulses a few cycles apart, so the writer comes back to frame 0 while only part of it has been read. The outputs must show a single overflow naming frame 0, an intact prefix of frame 0 with no last marker, and correct readout of the frame written afterwards. A second coincidence is checked separately: a word and a synch pulse in the same cycle, where the word must open the new frame and not close the old one.

// File: rtl/sbuf_pkg.sv
// Package: shared constants and helpers for the four-frame ring buffer.
// Assumes the ring is always exactly four frames deep.
package sbuf_pkg;
    localparam int NFRAMES = 4;
    localparam int FIDX_W  = 2;

    typedef logic [FIDX_W-1:0] fidx_t;

    typedef enum logic {
        W_IDLE = 1'b0,
        W_RUN  = 1'b1
    } wr_state_t;

    // Successor of a frame index in the ring.
    function automatic fidx_t next_frame(input fidx_t f);
        return fidx_t'((int'(f) + 1) % NFRAMES);
    endfunction
endpackage

// File: rtl/sbuf_mem.sv
// Module: sbuf_mem
// Single-port behavioural word memory with a free-running slot toggle.
// Even slots carry writes and odd slots carry reads, so one port serves both
// sides. Assumes the clients only request access in their own slot.
module sbuf_mem #(
    parameter int WORD_W = 32,
    parameter int DEPTH  = 64,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WORD_W-1:0] wdata,
    input  logic              re,
    input  logic [AW-1:0]     raddr,
    output logic              wr_slot,
    output logic [WORD_W-1:0] rdata
);
    logic              rd_phase;
    logic [AW-1:0]     port_addr;
    logic [WORD_W-1:0] store [DEPTH];

    // Slot toggle: flips every cycle from reset onward.
    always_ff @(posedge clk) begin
        if (!rst_n) rd_phase <= 1'b0;
        else        rd_phase <= ~rd_phase;
    end

    assign wr_slot = ~rd_phase;

    // Single address port: the slot decides which client owns it.
    always_comb port_addr = rd_phase ? raddr : waddr;

    // Memory access: write in the write slot, registered read in the read slot.
    always_ff @(posedge clk) begin
        if (!rd_phase && we) store[port_addr] <= wdata;
        if (rd_phase && re)  rdata <= store[port_addr];
    end

    p_write_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        we |-> !rd_phase);
    p_read_in_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        re |-> rd_phase);
endmodule

// File: rtl/sbuf_writer.sv
// Module: sbuf_writer
// Write pointer for the frame ring. It opens frame 0 on the first synch after
// init, then closes and advances one frame per synch pulse. It gathers the
// trigger mark per frame and raises overflow when re-entering a frame that is
// still pending readout. It never stalls writes. Assumes words arrive only
// in write slots.
module sbuf_writer
    import sbuf_pkg::*;
#(
    parameter int WPF    = 16,
    parameter int WORD_W = 32,
    localparam int LEN_W = $clog2(WPF + 1),
    localparam int AW    = $clog2(NFRAMES * WPF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_i,
    input  logic               sync_i,
    input  logic               trig_i,
    input  logic               word_valid_i,
    input  logic [WORD_W-1:0]  word_i,
    input  logic               wr_slot_i,
    input  logic [NFRAMES-1:0] pending_i,
    output logic               we_o,
    output logic [AW-1:0]      waddr_o,
    output logic [WORD_W-1:0]  wdata_o,
    output logic               close_v_o,
    output fidx_t              close_frame_o,
    output logic [LEN_W-1:0]   close_len_o,
    output logic               close_trig_o,
    output logic               skip_v_o,
    output fidx_t              skip_frame_o,
    output fidx_t              wr_frame_o,
    output logic               running_o,
    output logic               ovf_o,
    output fidx_t              ovf_frame_o
);
    wr_state_t        st;
    fidx_t            wr_frame;
    logic [LEN_W-1:0] fill;
    logic             trig_cur;

    logic             open_first, roll, live, take;
    fidx_t            nxt, eff_frame;
    logic [LEN_W-1:0] eff_addr;

    // Decode this cycle's synch event and the target location of a word.
    always_comb begin
        open_first = sync_i && !init_i && (st == W_IDLE);
        roll       = sync_i && !init_i && (st == W_RUN);
        live       = !init_i && ((st == W_RUN) || open_first);
        nxt        = next_frame(wr_frame);
        eff_frame  = roll ? nxt : wr_frame;
        eff_addr   = (roll || open_first) ? '0 : fill;
        take       = live && word_valid_i && wr_slot_i;
    end

    // Memory request: only while room is left in the frame.
    always_comb begin
        we_o    = take && (eff_addr < LEN_W'(WPF));
        waddr_o = AW'(int'(eff_frame) * WPF + int'(eff_addr));
        wdata_o = word_i;
    end

    // Frame close and skip notices for the reader.
    always_comb begin
        close_v_o     = roll;
        close_frame_o = wr_frame;
        close_len_o   = fill;
        close_trig_o  = trig_cur;
        skip_v_o      = roll && pending_i[nxt];
        skip_frame_o  = nxt;
    end

    // Pointer, fill count, trigger mark and overflow pulse.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            st          <= W_IDLE;
            wr_frame    <= '0;
            fill        <= '0;
            trig_cur    <= 1'b0;
            ovf_o       <= 1'b0;
            ovf_frame_o <= '0;
        end else begin
            ovf_o <= skip_v_o;
            if (skip_v_o)   ovf_frame_o <= nxt;
            if (open_first) st <= W_RUN;
            if (roll)       wr_frame <= nxt;
            if (live) begin
                fill     <= we_o ? eff_addr + LEN_W'(1) : eff_addr;
                trig_cur <= ((roll || open_first) ? 1'b0 : trig_cur) | trig_i;
            end
        end
    end

    assign wr_frame_o = wr_frame;
    assign running_o  = (st == W_RUN);

    p_fill_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        fill <= LEN_W'(WPF));
    p_ring_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (running_o && $past(running_o) && (wr_frame != $past(wr_frame)))
        |-> (wr_frame == next_frame($past(wr_frame))));
endmodule

// File: rtl/sbuf_reader.sv
// Module: sbuf_reader
// Readout side of the frame ring. It keeps a pending flag, length and trigger
// mark per closed frame, and walks the frames oldest first. It issues one
// read per read slot and tags each returned word. Empty frames are retired
// in one cycle without output. A skip notice drops a pending frame and moves
// on. Assumes the writer never closes a frame that is still pending.
module sbuf_reader
    import sbuf_pkg::*;
#(
    parameter int WPF    = 16,
    localparam int LEN_W = $clog2(WPF + 1),
    localparam int AW    = $clog2(NFRAMES * WPF)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_i,
    input  logic               close_v_i,
    input  fidx_t              close_frame_i,
    input  logic [LEN_W-1:0]   close_len_i,
    input  logic               close_trig_i,
    input  logic               skip_v_i,
    input  fidx_t              skip_frame_i,
    input  logic               wr_slot_i,
    output logic               re_o,
    output logic [AW-1:0]      raddr_o,
    output logic [NFRAMES-1:0] pending_o,
    output logic               out_valid_o,
    output logic               out_trig_o,
    output fidx_t              out_frame_o,
    output logic               out_first_o,
    output logic               out_last_o
);
    logic [NFRAMES-1:0] pending;
    logic [NFRAMES-1:0] ftrig;
    logic [LEN_W-1:0]   flen [NFRAMES];
    fidx_t              rd_frame;
    logic [LEN_W-1:0]   rpos;

    logic cur_empty, skip_hit, is_last;

    // Current-frame status and the read request for this slot.
    always_comb begin
        skip_hit  = skip_v_i && (skip_frame_i == rd_frame);
        cur_empty = pending[rd_frame] && (flen[rd_frame] == '0);
        is_last   = (rpos == flen[rd_frame] - LEN_W'(1));
        re_o      = !wr_slot_i && !init_i && pending[rd_frame] &&
                    !cur_empty && !skip_hit;
        raddr_o   = AW'(int'(rd_frame) * WPF + int'(rpos));
    end

    // Pending bookkeeping, read walk and output tags.
    always_ff @(posedge clk) begin
        if (!rst_n || init_i) begin
            pending     <= '0;
            ftrig       <= '0;
            rd_frame    <= '0;
            rpos        <= '0;
            out_valid_o <= 1'b0;
            out_trig_o  <= 1'b0;
            out_frame_o <= '0;
            out_first_o <= 1'b0;
            out_last_o  <= 1'b0;
            for (int i = 0; i < NFRAMES; i++) flen[i] <= '0;
        end else begin
            out_valid_o <= re_o;
            if (re_o) begin
                out_trig_o  <= ftrig[rd_frame];
                out_frame_o <= rd_frame;
                out_first_o <= (rpos == '0);
                out_last_o  <= is_last;
                if (is_last) begin
                    pending[rd_frame] <= 1'b0;
                    rd_frame          <= next_frame(rd_frame);
                    rpos              <= '0;
                end else begin
                    rpos <= rpos + LEN_W'(1);
                end
            end else if (cur_empty && !skip_hit) begin
                pending[rd_frame] <= 1'b0;
                rd_frame          <= next_frame(rd_frame);
            end
            if (skip_v_i) begin
                pending[skip_frame_i] <= 1'b0;
                if (skip_hit) begin
                    rd_frame <= next_frame(skip_frame_i);
                    rpos     <= '0;
                end
            end
            if (close_v_i) begin
                pending[close_frame_i] <= 1'b1;
                flen[close_frame_i]    <= close_len_i;
                ftrig[close_frame_i]   <= close_trig_i;
            end
        end
    end

    assign pending_o = pending;

    p_out_spaced_r2: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |=> !out_valid_o);
    p_close_pends_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (close_v_i && !init_i) |=> pending[$past(close_frame_i)]);
    p_skip_drops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (skip_v_i && !init_i) |=> !pending[$past(skip_frame_i)]);
endmodule

// File: rtl/sbuf_frame_ring.sv
// Module: sbuf_frame_ring (top)
// Four-frame ring sample buffer. It joins the write pointer, the readout walk
// and the slot-shared memory, and splits readout onto a priority strobe and a
// continuous strobe by each frame's trigger mark. Assumes the word source
// watches word_slot_o and presents at most one word per write slot.
module sbuf_frame_ring
    import sbuf_pkg::*;
#(
    parameter int SAMPLE_W        = 16,
    parameter int WORDS_PER_FRAME = 16,
    localparam int WORD_W         = 2 * SAMPLE_W,
    localparam int DEPTH          = NFRAMES * WORDS_PER_FRAME,
    localparam int AW             = $clog2(DEPTH),
    localparam int LEN_W          = $clog2(WORDS_PER_FRAME + 1)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               init_i,
    input  logic               frame_sync_i,
    input  logic               trigger_i,
    input  logic               word_valid_i,
    input  logic [WORD_W-1:0]  word_i,
    output logic               word_slot_o,
    output logic               pri_valid_o,
    output logic               cont_valid_o,
    output logic [WORD_W-1:0]  rd_data_o,
    output logic [FIDX_W-1:0]  rd_frame_o,
    output logic               rd_first_o,
    output logic               rd_last_o,
    output logic [FIDX_W-1:0]  wr_frame_o,
    output logic               running_o,
    output logic [NFRAMES-1:0] frame_ready_o,
    output logic               ovf_o,
    output logic [FIDX_W-1:0]  ovf_frame_o
);
    logic              we, re, wr_slot;
    logic [AW-1:0]     waddr, raddr;
    logic [WORD_W-1:0] wdata, rdata;
    logic              close_v, close_trig, skip_v;
    fidx_t             close_frame, skip_frame, wr_frame, ovf_frame, out_frame;
    logic [LEN_W-1:0]  close_len;
    logic [NFRAMES-1:0] pending;
    logic              out_valid, out_trig, out_first, out_last, running, ovf;

    sbuf_writer #(.WPF(WORDS_PER_FRAME), .WORD_W(WORD_W)) u_writer (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .sync_i(frame_sync_i),
        .trig_i(trigger_i), .word_valid_i(word_valid_i), .word_i(word_i),
        .wr_slot_i(wr_slot), .pending_i(pending), .we_o(we), .waddr_o(waddr),
        .wdata_o(wdata), .close_v_o(close_v), .close_frame_o(close_frame),
        .close_len_o(close_len), .close_trig_o(close_trig), .skip_v_o(skip_v),
        .skip_frame_o(skip_frame), .wr_frame_o(wr_frame), .running_o(running),
        .ovf_o(ovf), .ovf_frame_o(ovf_frame)
    );

    sbuf_reader #(.WPF(WORDS_PER_FRAME)) u_reader (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .close_v_i(close_v),
        .close_frame_i(close_frame), .close_len_i(close_len),
        .close_trig_i(close_trig), .skip_v_i(skip_v), .skip_frame_i(skip_frame),
        .wr_slot_i(wr_slot), .re_o(re), .raddr_o(raddr), .pending_o(pending),
        .out_valid_o(out_valid), .out_trig_o(out_trig), .out_frame_o(out_frame),
        .out_first_o(out_first), .out_last_o(out_last)
    );

    sbuf_mem #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_mem (
        .clk(clk), .rst_n(rst_n), .we(we), .waddr(waddr), .wdata(wdata),
        .re(re), .raddr(raddr), .wr_slot(wr_slot), .rdata(rdata)
    );

    // Output routing: trigger mark picks the strobe, tags pass through.
    always_comb begin
        word_slot_o   = wr_slot;
        pri_valid_o   = out_valid && out_trig;
        cont_valid_o  = out_valid && !out_trig;
        rd_data_o     = rdata;
        rd_frame_o    = out_frame;
        rd_first_o    = out_first;
        rd_last_o     = out_last;
        wr_frame_o    = wr_frame;
        running_o     = running;
        frame_ready_o = pending;
        ovf_o         = ovf;
        ovf_frame_o   = ovf_frame;
    end

    p_init_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        init_i |=> (wr_frame_o == '0 && !running_o && frame_ready_o == '0 &&
                    !pri_valid_o && !cont_valid_o));
    p_ovf_frame_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_o |-> !frame_ready_o[ovf_frame_o]);
    p_paths_exclusive_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(pri_valid_o && cont_valid_o));
endmodule

// File: tb/sbuf_frame_ring_tb.sv
`timescale 1ns/1ps
module sbuf_frame_ring_tb_top;
    localparam int WPF = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        init_i = 1'b0, frame_sync_i = 1'b0, trigger_i = 1'b0;
    logic        word_valid_i = 1'b0;
    logic [31:0] word_i = '0;
    logic        word_slot_o, pri_valid_o, cont_valid_o, rd_first_o, rd_last_o;
    logic        running_o, ovf_o;
    logic [31:0] rd_data_o;
    logic [1:0]  rd_frame_o, wr_frame_o, ovf_frame_o;
    logic [3:0]  frame_ready_o;

    sbuf_frame_ring #(.SAMPLE_W(16), .WORDS_PER_FRAME(WPF)) dut_i (
        .clk(clk), .rst_n(rst_n), .init_i(init_i), .frame_sync_i(frame_sync_i),
        .trigger_i(trigger_i), .word_valid_i(word_valid_i), .word_i(word_i),
        .word_slot_o(word_slot_o), .pri_valid_o(pri_valid_o),
        .cont_valid_o(cont_valid_o), .rd_data_o(rd_data_o),
        .rd_frame_o(rd_frame_o), .rd_first_o(rd_first_o), .rd_last_o(rd_last_o),
        .wr_frame_o(wr_frame_o), .running_o(running_o),
        .frame_ready_o(frame_ready_o), .ovf_o(ovf_o), .ovf_frame_o(ovf_frame_o)
    );

    always #2.5 clk = ~clk;

    int checks = 0, fails = 0;
    bit done = 0;
    int cyc_cnt = 0;
    int cap_n = 0, ovf_cnt = 0;
    logic [1:0]  ovf_last;
    logic [31:0] cap_d [256];
    logic [1:0]  cap_f [256];
    bit          cap_p [256], cap_fi [256], cap_la [256];
    int          cap_t [256];

    always @(posedge clk) cyc_cnt <= cyc_cnt + 1;

    // Output monitor: records every readout word and overflow pulse.
    always @(negedge clk) begin
        if ((pri_valid_o || cont_valid_o) && cap_n < 256) begin
            cap_d[cap_n] = rd_data_o;  cap_f[cap_n] = rd_frame_o;
            cap_p[cap_n] = pri_valid_o; cap_fi[cap_n] = rd_first_o;
            cap_la[cap_n] = rd_last_o; cap_t[cap_n] = cyc_cnt;
            cap_n++;
        end
        if (ovf_o) begin
            ovf_cnt++;
            ovf_last = ovf_frame_o;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_caps();
        @(posedge clk);
        cap_n = 0;
        ovf_cnt = 0;
    endtask

    task automatic put_word(input logic [31:0] d);
        @(negedge clk);
        while (!word_slot_o) @(negedge clk);
        word_valid_i = 1'b1; word_i = d;
        @(negedge clk);
        word_valid_i = 1'b0;
    endtask

    task automatic sync_pulse(input bit trig);
        @(negedge clk);
        frame_sync_i = 1'b1; trigger_i = trig;
        @(negedge clk);
        frame_sync_i = 1'b0; trigger_i = 1'b0;
    endtask

    task automatic trig_pulse();
        @(negedge clk);
        trigger_i = 1'b1;
        @(negedge clk);
        trigger_i = 1'b0;
    endtask

    // Compare one captured word against data, frame, path and markers.
    task automatic exp_cap(input string req, input int i, input logic [31:0] d,
                           input logic [1:0] f, input bit p, input bit fi, input bit la);
        chk({req, " data"}, cap_d[i], d);
        chk({req, " tags"}, {27'd0, cap_f[i], cap_p[i], cap_fi[i], cap_la[i]},
            {27'd0, f, p, fi, la});
    endtask

    task automatic t_reset();
        chk("R1 reset wr_frame", 32'(wr_frame_o), 0);
        chk("R1 reset running", 32'(running_o), 0);
        chk("R1 reset ready", 32'(frame_ready_o), 0);
        chk("R1 reset strobes", 32'({pri_valid_o, cont_valid_o, ovf_o}), 0);
    endtask

    task automatic t_init_hold();
        clear_caps();
        init_i = 1'b1;
        sync_pulse(0);
        for (int i = 0; i < 3; i++) put_word(32'hBAD0_0000 + 32'(i));
        sync_pulse(1);
        cyc(10);
        chk("R1 init running", 32'(running_o), 0);
        chk("R1 init wr_frame", 32'(wr_frame_o), 0);
        chk("R1 init ready", 32'(frame_ready_o), 0);
        chk("R1 init no output", 32'(cap_n), 0);
        init_i = 1'b0;
        cyc(2);
        chk("R1 waits for synch", 32'(running_o), 0);
    endtask

    task automatic t_basic();
        clear_caps();
        sync_pulse(0);
        chk("R1 start running", 32'(running_o), 1);
        chk("R1 start frame0", 32'(wr_frame_o), 0);
        for (int i = 0; i < 5; i++) put_word(32'hA000_0000 + 32'(i));
        sync_pulse(0);
        chk("R3 advance to 1", 32'(wr_frame_o), 1);
        cyc(30);
        chk("R4 count", 32'(cap_n), 5);
        for (int i = 0; i < 5; i++)
            exp_cap("R4 basic", i, 32'hA000_0000 + 32'(i), 2'd0, 0, i == 0, i == 4);
        for (int i = 1; i < 5; i++)
            chk("R2 spacing", 32'(cap_t[i] - cap_t[i-1] >= 2), 1);
        chk("R4 ready cleared", 32'(frame_ready_o), 0);
    endtask

    task automatic t_trigger();
        clear_caps();
        for (int i = 0; i < 3; i++) put_word(32'hB100_0000 + 32'(i));
        trig_pulse();
        put_word(32'hB100_0003);
        sync_pulse(0);
        cyc(30);
        chk("R5 count", 32'(cap_n), 4);
        for (int i = 0; i < 4; i++)
            exp_cap("R5 priority", i, 32'hB100_0000 + 32'(i), 2'd1, 1, i == 0, i == 3);
    endtask

    task automatic t_wrap();
        clear_caps();
        put_word(32'hC200_0000); put_word(32'hC200_0001);
        sync_pulse(0);
        chk("R3 advance to 3", 32'(wr_frame_o), 3);
        put_word(32'hC300_0000); put_word(32'hC300_0001);
        sync_pulse(0);
        chk("R3 wrap to 0", 32'(wr_frame_o), 0);
        put_word(32'hC000_0000); put_word(32'hC000_0001);
        sync_pulse(0);
        chk("R3 advance to 1 again", 32'(wr_frame_o), 1);
        cyc(30);
        chk("R4 wrap count", 32'(cap_n), 6);
        exp_cap("R4 wrap", 0, 32'hC200_0000, 2'd2, 0, 1, 0);
        exp_cap("R4 wrap", 1, 32'hC200_0001, 2'd2, 0, 0, 1);
        exp_cap("R4 wrap", 2, 32'hC300_0000, 2'd3, 0, 1, 0);
        exp_cap("R4 wrap", 3, 32'hC300_0001, 2'd3, 0, 0, 1);
        exp_cap("R4 wrap", 4, 32'hC000_0000, 2'd0, 0, 1, 0);
        exp_cap("R4 wrap", 5, 32'hC000_0001, 2'd0, 0, 0, 1);
    endtask

    task automatic t_capacity();
        clear_caps();
        for (int i = 0; i < WPF + 3; i++) put_word(32'hD100_0000 + 32'(i));
        sync_pulse(0);
        cyc(2 * WPF + 20);
        chk("R6 count", 32'(cap_n), WPF);
        for (int i = 0; i < WPF; i++)
            exp_cap("R6 capacity", i, 32'hD100_0000 + 32'(i), 2'd1, 0, i == 0, i == WPF - 1);
    endtask

    task automatic t_sync_word();
        clear_caps();
        put_word(32'hE200_0000); put_word(32'hE200_0001);
        @(negedge clk);
        while (!word_slot_o) @(negedge clk);
        frame_sync_i = 1'b1; word_valid_i = 1'b1; word_i = 32'hE300_0000;
        @(negedge clk);
        frame_sync_i = 1'b0; word_valid_i = 1'b0;
        put_word(32'hE300_0001);
        sync_pulse(0);
        cyc(30);
        chk("R8 count", 32'(cap_n), 4);
        exp_cap("R8 old frame", 1, 32'hE200_0001, 2'd2, 0, 0, 1);
        exp_cap("R8 new first", 2, 32'hE300_0000, 2'd3, 0, 1, 0);
        exp_cap("R8 new second", 3, 32'hE300_0001, 2'd3, 0, 0, 1);
    endtask

    task automatic t_overflow();
        bit any_last;
        clear_caps();
        for (int i = 0; i < WPF; i++) put_word(32'hF000_0000 + 32'(i));
        sync_pulse(0);
        cyc(2); sync_pulse(0);
        cyc(2); sync_pulse(0);
        cyc(2); sync_pulse(0);
        cyc(4);
        chk("R7 ovf count", 32'(ovf_cnt), 1);
        chk("R7 ovf frame", 32'(ovf_last), 0);
        chk("R7 writer continues", 32'(wr_frame_o), 0);
        cyc(2 * WPF + 10);
        chk("R7 partial nonempty", 32'(cap_n > 0), 1);
        chk("R7 partial short", 32'(cap_n < WPF), 1);
        any_last = 0;
        for (int i = 0; i < cap_n; i++) begin
            chk("R7 prefix data", cap_d[i], 32'hF000_0000 + 32'(i));
            if (cap_la[i]) any_last = 1;
        end
        chk("R7 no last marker", 32'(any_last), 0);
        clear_caps();
        put_word(32'hF0A0_0000); put_word(32'hF0A0_0001);
        sync_pulse(0);
        cyc(20);
        chk("R7 after skip count", 32'(cap_n), 2);
        exp_cap("R7 after skip", 0, 32'hF0A0_0000, 2'd0, 0, 1, 0);
        exp_cap("R7 after skip", 1, 32'hF0A0_0001, 2'd0, 0, 0, 1);
        chk("R7 ovf quiet", 32'(ovf_cnt), 0);
    endtask

    task automatic t_init_run();
        clear_caps();
        put_word(32'h9100_0000); put_word(32'h9100_0001);
        @(negedge clk); init_i = 1'b1;
        cyc(2);
        chk("R9 wr_frame", 32'(wr_frame_o), 0);
        chk("R9 running", 32'(running_o), 0);
        chk("R9 ready", 32'(frame_ready_o), 0);
        init_i = 1'b0;
        cyc(20);
        chk("R9 discarded", 32'(cap_n), 0);
        sync_pulse(0);
        chk("R1 restart frame0", 32'(wr_frame_o), 0);
        put_word(32'h9000_0000);
        sync_pulse(0);
        cyc(20);
        chk("R9 fresh count", 32'(cap_n), 1);
        exp_cap("R9 fresh", 0, 32'h9000_0000, 2'd0, 0, 1, 1);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_init_hold();
        t_basic();
        t_trigger();
        t_wrap();
        t_capacity();
        t_sync_word();
        t_overflow();
        t_init_run();
        done = 1;
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc_cnt, 0);
            $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule